// File: doc/BRIEF.md
# I/O Bank Freeze/Thaw Sequencer

This block parks one bank of general-purpose pads in a safe state and later hands them back to their normal configuration. Software steers it through a single 32-bit control word. One bit asks for the bank to be frozen or thawed. A two-bit read-only field reports where the sequencer is: stable thawed, stable frozen, or one of the two transitional states between them. While the bank is frozen, every pad has its output driver disabled and its weak pull-up enabled, whatever the per-pin configuration asks for. While the bank is thawed, the configuration passes straight through.

A freeze first disables the drivers and then enables the pull-ups. A thaw does the same in reverse: it releases the pull-ups first and the drivers after. Each step lasts a parameterised number of clock cycles so that the pads can settle. The control word is cleared only by the cold reset, which leaves the bank frozen. The warm reset leaves the request, the status and any sequence in progress untouched. Software requests a change and then polls the status field until the matching stable code appears.

Top module: `iofrz_ctrl`

## Requirements
- R1: While cold reset is asserted and after it is released, the control word reads 0x5 (request = 1, status = 2, frozen), every `pad_oe` bit is 0 and every `pad_pu` bit is 1.
- R2: The control word is decoded at byte address 0x58 only. Bit 0 is the request, bits 2:1 are the status, and bits 31:3 read 0. A read at any other address returns 0.
- R3: Writes to the status bits, to bits 31:3, or to any address other than 0x58 change nothing.
- R4: Writing request = 1 while thawed makes the status read 0 after the next clock edge. For the first STEP_CYC cycles, `pad_oe` is all 0 and `pad_pu` follows `pad_cfg_pu`. For the next STEP_CYC cycles, `pad_pu` is all 1. The status then reads 2.
- R5: Writing request = 0 while frozen makes the status read 3 after the next clock edge. For the first STEP_CYC cycles, `pad_pu` follows its configuration and `pad_oe` stays all 0. For the next STEP_CYC cycles, `pad_oe` also follows its configuration. The status then reads 1.
- R6: With status 2, `pad_oe` is all 0 and `pad_pu` is all 1 for every configuration input.
- R7: With status 1, `pad_oe` equals `pad_cfg_oe` and `pad_pu` equals `pad_cfg_pu`.
- R8: A request written during a transition does not abort the transition. If the request then disagrees with the stable state reached, the opposite transition starts one cycle after that state is reached.
- R9: While `warm_rst_n` is low, the request and status keep their values, a transition in progress continues, and register writes are dropped.
- R10: The status moves only along 1→0, 0→2, 2→3 and 3→1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous active-low cold reset; clears the control word |
| warm_rst_n | input | 1 | Active-low warm reset; blocks writes and holds no other effect |
| reg_wen | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (8) | Byte address for reads and writes |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| pad_cfg_oe | input | NPIN (8) | Configured output enable per pin |
| pad_cfg_pu | input | NPIN (8) | Configured pull-up enable per pin |
| pad_oe | output | NPIN (8) | Output enable driven to the pads |
| pad_pu | output | NPIN (8) | Weak pull-up enable driven to the pads |

## Verification
A wrong sequencer state shows up on the pad controls in the same cycle, because both overrides are decoded directly from the state register. It also shows up in the status field the moment the control word is read. A step counter that is off by one moves the edge where the drivers or the pull-ups change by one cycle, and it moves the arrival of the stable code by one or two cycles. The bench therefore compares every cycle of each sequence, not only its end point. A request that is latched at the wrong time, or that is lost, appears either as a transition starting one cycle early or late after a stable state is reached, or as one that never starts.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;
   // Status codes; the software-visible encoding fixes these values.
   typedef enum logic [1:0] {
      ST_TO_FRZ  = 2'd0,
      ST_THAWED  = 2'd1,
      ST_FROZEN  = 2'd2,
      ST_TO_THAW = 2'd3
   } frz_st_e;

   localparam int REQ_BIT  = 0;
   localparam int STAT_LSB = 1;
endpackage

// File: rtl/iofrz_regif.sv
module iofrz_regif #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int REG_OFFSET = 'h58
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              wen,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wbit,
   input  logic [1:0]        st,
   output logic [DATA_W-1:0] rdata,
   output logic              req
);
   import iofrz_pkg::*;

   localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFFSET);

   logic hit;
   assign hit = (addr == OFS);

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n)
         req <= 1'b1;
      else if (wen && hit && warm_rst_n)
         req <= wbit;
   end

   always_comb begin
      rdata = '0;
      if (hit) begin
         rdata[REQ_BIT]            = req;
         rdata[STAT_LSB+1:STAT_LSB] = st;
      end
   end
endmodule

// File: rtl/iofrz_seq.sv
module iofrz_seq #(
   parameter int STEP_CYC = 4
) (
   input  logic       clk,
   input  logic       cold_rst_n,
   input  logic       req,
   output logic [1:0] st,
   output logic       force_tri,
   output logic       force_pu
);
   import iofrz_pkg::*;

   localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);

   frz_st_e        st_q, st_d;
   logic           ph_q, ph_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      ph_d  = ph_q;
      cnt_d = cnt_q;
      unique case (st_q)
         ST_THAWED: if (req) begin
            st_d  = ST_TO_FRZ;
            ph_d  = 1'b0;
            cnt_d = '0;
         end
         ST_FROZEN: if (!req) begin
            st_d  = ST_TO_THAW;
            ph_d  = 1'b0;
            cnt_d = '0;
         end
         default: begin
            if (cnt_q == LAST) begin
               cnt_d = '0;
               if (!ph_q) begin
                  ph_d = 1'b1;
               end else begin
                  ph_d = 1'b0;
                  st_d = (st_q == ST_TO_FRZ) ? ST_FROZEN : ST_THAWED;
               end
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge cold_rst_n) begin
      if (!cold_rst_n) begin
         st_q  <= ST_FROZEN;
         ph_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   // Drivers stay off everywhere except thawed and the second thaw step.
   assign force_tri = (st_q != ST_THAWED) && !(st_q == ST_TO_THAW && ph_q);
   // Pull-ups are forced only when frozen and in the second freeze step.
   assign force_pu  = (st_q == ST_FROZEN) || (st_q == ST_TO_FRZ && ph_q);
   assign st        = st_q;
endmodule

// File: rtl/iofrz_padgate.sv
module iofrz_padgate #(
   parameter int NPIN    = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            cold_rst_n,
   input  logic            force_tri,
   input  logic            force_pu,
   input  logic [NPIN-1:0] cfg_oe,
   input  logic [NPIN-1:0] cfg_pu,
   output logic [NPIN-1:0] pad_oe,
   output logic [NPIN-1:0] pad_pu
);
   logic [NPIN-1:0] oe_c, pu_c;

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign oe_c[p] = cfg_oe[p] & ~force_tri;
      assign pu_c[p] = cfg_pu[p] |  force_pu;
   end

   if (OUT_REG) begin : g_flop
      always_ff @(posedge clk or negedge cold_rst_n) begin
         if (!cold_rst_n) begin
            pad_oe <= '0;
            pad_pu <= '1;
         end else begin
            pad_oe <= oe_c;
            pad_pu <= pu_c;
         end
      end
   end else begin : g_comb
      assign pad_oe = oe_c;
      assign pad_pu = pu_c;
   end
endmodule

// File: rtl/iofrz_ctrl.sv
module iofrz_ctrl #(
   parameter int NPIN       = 8,
   parameter int STEP_CYC   = 4,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int REG_OFFSET = 'h58,
   parameter bit OUT_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic              reg_wen,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPIN-1:0]   pad_cfg_oe,
   input  logic [NPIN-1:0]   pad_cfg_pu,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN-1:0]   pad_pu
);
   if (NPIN < 1) begin : g_chk_npin
      $error("NPIN must be at least 1");
   end
   if (STEP_CYC < 1) begin : g_chk_step
      $error("STEP_CYC must be at least 1");
   end
   if (DATA_W < 3) begin : g_chk_dw
      $error("DATA_W must hold request and status");
   end
   if (REG_OFFSET >= (1 << ADDR_W)) begin : g_chk_ofs
      $error("REG_OFFSET outside address space");
   end

   logic       req;
   logic [1:0] st;
   logic       force_tri, force_pu;

   iofrz_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
   ) u_regif (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .wen(reg_wen), .addr(reg_addr), .wbit(reg_wdata[0]),
      .st(st), .rdata(reg_rdata), .req(req)
   );

   iofrz_seq #(.STEP_CYC(STEP_CYC)) u_seq (
      .clk(clk), .cold_rst_n(cold_rst_n), .req(req),
      .st(st), .force_tri(force_tri), .force_pu(force_pu)
   );

   iofrz_padgate #(.NPIN(NPIN), .OUT_REG(OUT_REG)) u_pad (
      .clk(clk), .cold_rst_n(cold_rst_n),
      .force_tri(force_tri), .force_pu(force_pu),
      .cfg_oe(pad_cfg_oe), .cfg_pu(pad_cfg_pu),
      .pad_oe(pad_oe), .pad_pu(pad_pu)
   );
endmodule

// File: rtl/iofrz_ctrl_chk.sv
module iofrz_ctrl_chk #(
   parameter int NPIN       = 8,
   parameter int ADDR_W     = 8,
   parameter int REG_OFFSET = 'h58,
   parameter bit OUT_REG    = 1'b0
) (
   input logic              clk,
   input logic              cold_rst_n,
   input logic              warm_rst_n,
   input logic              reg_wen,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [1:0]        st,
   input logic              req,
   input logic [NPIN-1:0]   pad_cfg_oe,
   input logic [NPIN-1:0]   pad_cfg_pu,
   input logic [NPIN-1:0]   pad_oe,
   input logic [NPIN-1:0]   pad_pu
);
   a_r10_legal_step: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (st != $past(st)) |->
         (($past(st) == 2'd1 && st == 2'd0) || ($past(st) == 2'd0 && st == 2'd2) ||
          ($past(st) == 2'd2 && st == 2'd3) || ($past(st) == 2'd3 && st == 2'd1)));

   a_r8_freeze_no_abort: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (st == 2'd0) |=> (st == 2'd0 || st == 2'd2));

   a_r8_thaw_no_abort: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (st == 2'd3) |=> (st == 2'd3 || st == 2'd1));

   a_r9_warm_holds_req: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (!warm_rst_n) |=> (req == $past(req)));

   a_r3_foreign_write: assert property (@(posedge clk) disable iff (!cold_rst_n)
      (reg_wen && reg_addr != ADDR_W'(REG_OFFSET)) |=> (req == $past(req)));

   if (!OUT_REG) begin : g_pad_props
      a_r6_frozen_pads: assert property (@(posedge clk) disable iff (!cold_rst_n)
         (st == 2'd2) |-> (pad_oe == '0 && pad_pu == '1));

      a_r7_thawed_pads: assert property (@(posedge clk) disable iff (!cold_rst_n)
         (st == 2'd1) |-> (pad_oe == pad_cfg_oe && pad_pu == pad_cfg_pu));

      a_r4_freeze_tristate: assert property (@(posedge clk) disable iff (!cold_rst_n)
         (st == 2'd0) |-> (pad_oe == '0));
   end
endmodule

bind iofrz_ctrl iofrz_ctrl_chk #(
   .NPIN(NPIN), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
   .reg_wen(reg_wen), .reg_addr(reg_addr), .st(st), .req(req),
   .pad_cfg_oe(pad_cfg_oe), .pad_cfg_pu(pad_cfg_pu),
   .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/iofrz_ctrl_test.sv
`timescale 1ns/1ps
module iofrz_ctrl_test;
   localparam int S = 4;

   logic        clk = 1'b0;
   always #10 clk = ~clk;

   logic        cold_rst_n, warm_rst_n, reg_wen;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata;
   logic [7:0]  pad_cfg_oe, pad_cfg_pu, pad_oe, pad_pu;

   int checks = 0;
   int errors = 0;

   iofrz_ctrl uut (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pad_cfg_oe(pad_cfg_oe), .pad_cfg_pu(pad_cfg_pu),
      .pad_oe(pad_oe), .pad_pu(pad_pu)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] exp;
   } vec_t;

   // Register-map vectors, run while frozen with request = 1 (R2, R3).
   localparam vec_t VT [8] = '{
      '{1'b1, 8'h58, 32'hFFFF_FFFF, 8'h58, 32'h5},
      '{1'b1, 8'h5C, 32'h0,         8'h58, 32'h5},
      '{1'b1, 8'h54, 32'h0,         8'h58, 32'h5},
      '{1'b1, 8'h59, 32'h0,         8'h58, 32'h5},
      '{1'b0, 8'h00, 32'h0,         8'h5C, 32'h0},
      '{1'b0, 8'h00, 32'h0,         8'h00, 32'h0},
      '{1'b1, 8'h58, 32'hFFFF_FFF9, 8'h58, 32'h5},
      '{1'b1, 8'hD8, 32'h0,         8'h58, 32'h5}
   };

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wen   = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wen   = 1'b0;
      reg_addr  = 8'h58;
   endtask

   task automatic pads(input string rq, input logic [7:0] eoe, input logic [7:0] epu);
      chk(rq, "pad_oe", {24'h0, pad_oe}, {24'h0, eoe});
      chk(rq, "pad_pu", {24'h0, pad_pu}, {24'h0, epu});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cold_rst_n = 1'b0; warm_rst_n = 1'b1; reg_wen = 1'b0;
      reg_addr = 8'h58; reg_wdata = '0;
      pad_cfg_oe = 8'hA5; pad_cfg_pu = 8'h3C;
      repeat (3) @(negedge clk);
      chk("R1", "word in reset", reg_rdata, 32'h5);
      pads("R1", 8'h00, 8'hFF);
      cold_rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "word after reset", reg_rdata, 32'h5);
      pads("R1", 8'h00, 8'hFF);

      // R6: frozen pads ignore configuration
      pad_cfg_oe = 8'hFF; pad_cfg_pu = 8'h00; #1;
      pads("R6", 8'h00, 8'hFF);

      for (int i = 0; i < 8; i++) begin
         if (VT[i].we) wr(VT[i].waddr, VT[i].wdata);
         reg_addr = VT[i].raddr; #1;
         chk("R2 R3", $sformatf("vector %0d", i), reg_rdata, VT[i].exp);
         reg_addr = 8'h58;
      end

      // R5 thaw sequence, checked every cycle
      pad_cfg_oe = 8'hA5; pad_cfg_pu = 8'h3C;
      wr(8'h58, 32'h0);
      chk("R5", "status before edge", {30'h0, reg_rdata[2:1]}, 32'd2);
      for (int i = 1; i <= 2*S+1; i++) begin
         @(negedge clk);
         if (i <= S) begin
            chk("R5", "status step1", {30'h0, reg_rdata[2:1]}, 32'd3);
            pads("R5", 8'h00, 8'h3C);
         end else if (i <= 2*S) begin
            chk("R5", "status step2", {30'h0, reg_rdata[2:1]}, 32'd3);
            pads("R5", 8'hA5, 8'h3C);
         end else begin
            chk("R5 R10", "status end", {30'h0, reg_rdata[2:1]}, 32'd1);
            pads("R5", 8'hA5, 8'h3C);
         end
      end

      // R7: thawed pads follow configuration
      pad_cfg_oe = 8'h0F; pad_cfg_pu = 8'hF0; #1; pads("R7", 8'h0F, 8'hF0);
      pad_cfg_oe = 8'hFF; pad_cfg_pu = 8'h00; #1; pads("R7", 8'hFF, 8'h00);
      pad_cfg_oe = 8'h5A; pad_cfg_pu = 8'h81; #1; pads("R7", 8'h5A, 8'h81);

      // R4 freeze sequence
      wr(8'h58, 32'h1);
      chk("R4", "status before edge", {30'h0, reg_rdata[2:1]}, 32'd1);
      for (int i = 1; i <= 2*S+1; i++) begin
         @(negedge clk);
         if (i <= S) begin
            chk("R4", "status step1", {30'h0, reg_rdata[2:1]}, 32'd0);
            pads("R4", 8'h00, 8'h81);
         end else if (i <= 2*S) begin
            chk("R4", "status step2", {30'h0, reg_rdata[2:1]}, 32'd0);
            pads("R4", 8'h00, 8'hFF);
         end else begin
            chk("R4 R10", "status end", {30'h0, reg_rdata[2:1]}, 32'd2);
            pads("R4", 8'h00, 8'hFF);
         end
      end

      // R8: request during a thaw is held until it completes
      wr(8'h58, 32'h0);
      repeat (2) @(negedge clk);
      wr(8'h58, 32'h1);
      for (int n = 0; n < 4*S; n++) begin
         if (reg_rdata[2:1] == 2'd1) break;
         chk("R8", "thaw not aborted", {30'h0, reg_rdata[2:1]}, 32'd3);
         @(negedge clk);
      end
      chk("R8", "thaw reached", {30'h0, reg_rdata[2:1]}, 32'd1);
      @(negedge clk);
      chk("R8", "held freeze starts", {30'h0, reg_rdata[2:1]}, 32'd0);
      repeat (2*S) @(negedge clk);
      chk("R8", "held freeze done", {30'h0, reg_rdata[2:1]}, 32'd2);

      // R9: warm reset during a thaw
      wr(8'h58, 32'h0);
      warm_rst_n = 1'b0;
      wr(8'h58, 32'h1);
      chk("R9", "request kept", {31'h0, reg_rdata[0]}, 32'd0);
      chk("R9", "status kept", {30'h0, reg_rdata[2:1]}, 32'd3);
      repeat (2*S) @(negedge clk);
      chk("R9", "thaw continues", reg_rdata, 32'h2);
      warm_rst_n = 1'b1;
      @(negedge clk);
      chk("R9", "stable after warm", reg_rdata, 32'h2);

      // R1: cold reset from thawed returns to frozen
      cold_rst_n = 1'b0; #1;
      chk("R1", "cold from thawed", reg_rdata, 32'h5);
      pads("R1", 8'h00, 8'hFF);
      @(negedge clk);
      cold_rst_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule